// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits behind the bus front end of a parallel flash macro. It watches write cycles (16-bit address, 16-bit data, single-cycle write strobe) and recognizes the keyed unlock sequences that start array operations. Each recognized sequence produces a one-cycle command pulse. The possible commands are word program (with the captured target address and data), chip erase, main-array erase, protection lockout, identification-mode entry and identification-mode exit.

Every keyed sequence starts with two unlock writes: low byte AA at address 5555, then low byte 55 at address 2AAA. A third write to 5555 then selects one of the following:
- program arming,
- identification entry,
- a second unlock pair that leads to a sixth selecting write.

A single write of F0 to any address leaves identification mode. The array engine, its timing and its status reporting live outside this block. The only feedback the block takes from them is a busy flag and the protection-lock state.

The block also holds the identification-mode flag. While the flag is set, a read-data mux returns the manufacturer code, the device code and the lock status at offsets 0, 1 and 2.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After a synchronous active-low reset, all command pulses are 0, `id_mode_o` is 0 and `id_rd_data_o` is 0000.
- R2: The write sequence AA@5555, 55@2AAA, A0@5555 arms word program. The next accepted write gives a `cmd_prog_o` pulse, and `prog_addr_o`/`prog_data_o` show that write's full address and data. Those two outputs hold until the next program command. In this fourth write, low byte F0 is program data and not an exit.
- R3: Key matching looks only at data bits 7:0 and address bits 14:0. Data bits 15:8 and address bit 15 do not affect matching.
- R4: The sequence AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA followed by a sixth write at 5555 gives a pulse that depends on that write's low byte:
  - 10 gives `cmd_chip_erase_o`,
  - 30 gives `cmd_main_erase_o`,
  - 40 gives `cmd_lockout_o`.
- R5: `cmd_id_exit_o` pulses in two cases:
  - the three-write sequence ending in F0@5555,
  - any accepted write with low byte F0 at any address, in any decoder state except armed program.
  In both cases the decoder returns to idle.
- R6: While `id_mode_o` is 1, `id_rd_data_o` depends on `rd_offset_i` (bits 14:0 of the read address):
  - offset 0 returns 001F,
  - offset 1 returns 0087,
  - offset 2 returns `{15'b0, lock_status_i}` (bit 0 = 1 means locked),
  - any other offset returns 0000.
  While `id_mode_o` is 0, `id_rd_data_o` is 0000.
- R7: A write that breaks an expected sequence issues no command and returns the decoder to idle. That same write counts as a first unlock write if it is AA@5555.
- R8: A write strobe while `oe_n_i` is 0 is ignored: no state change and no command.
- R9: A write strobe while `busy_i` is 1 is ignored: no state change and no command.
- R10: Each command pulse lasts exactly one cycle. It appears in the cycle after the clock edge that samples the final write, and at most one command pulses per cycle.
- R11: `id_mode_o` goes to 1 in the cycle after a `cmd_id_enter_o` pulse. It goes to 0 in the cycle after a `cmd_id_exit_o` pulse, and it also goes to 0 on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb_i | input | 1 | One-cycle write strobe from the bus front end |
| wr_addr_i | input | 16 | Write address |
| wr_data_i | input | 16 | Write data |
| oe_n_i | input | 1 | Output enable, active low; low inhibits writes |
| busy_i | input | 1 | Array engine busy; writes are ignored while high |
| lock_status_i | input | 1 | Protection-lock state from the array engine |
| rd_offset_i | input | 15 | Read address bits 14:0 for identification reads |
| cmd_prog_o | output | 1 | Word program command pulse |
| prog_addr_o | output | 16 | Captured program address |
| prog_data_o | output | 16 | Captured program data |
| cmd_chip_erase_o | output | 1 | Chip erase command pulse |
| cmd_main_erase_o | output | 1 | Main-array erase command pulse |
| cmd_lockout_o | output | 1 | Protection lockout command pulse |
| cmd_id_enter_o | output | 1 | Identification entry command pulse |
| cmd_id_exit_o | output | 1 | Identification exit command pulse |
| id_mode_o | output | 1 | Identification mode flag |
| id_rd_data_o | output | 16 | Identification read data |

## Verification
The assertions check the following on every cycle:
- a strobe during busy or while output enable is low leaves the sequence state and the command output untouched;
- a program pulse only follows the armed state, and an erase or lockout pulse only follows the fully unlocked six-write state;
- every command follows an accepted write;
- the identification flag only rises after an entry pulse and only falls after an exit pulse.

Only the bench scenarios can show the following:
- the exact decoding of each code value;
- the don't-care handling of the upper data byte and address bit 15;
- the re-check of a breaking write as a new first unlock write;
- the F0 escape from a partial sequence;
- the identification read values.

// File: rtl/flash_cmd_pkg.sv
// Package: shared types and key codes for the flash command decoder.
// Assumes: key codes are compared on the low data byte only.
package flash_cmd_pkg;

    // Sequence position of the decoder.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_KEY1   = 3'd1,
        ST_KEY2   = 3'd2,
        ST_ARMED  = 3'd3,
        ST_EXT0   = 3'd4,
        ST_EXT1   = 3'd5,
        ST_EXT2   = 3'd6
    } seq_state_t;

    // Command issued; the value minus one is the pulse index at the top.
    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_PROG   = 3'd1,
        CMD_CHIP   = 3'd2,
        CMD_MAIN   = 3'd3,
        CMD_LOCK   = 3'd4,
        CMD_ID_IN  = 3'd5,
        CMD_ID_OUT = 3'd6
    } cmd_t;

    localparam int NUM_CMD = 6;

    localparam logic [7:0] CODE_KEY_A   = 8'hAA;
    localparam logic [7:0] CODE_KEY_B   = 8'h55;
    localparam logic [7:0] CODE_PROG    = 8'hA0;
    localparam logic [7:0] CODE_EXTEND  = 8'h80;
    localparam logic [7:0] CODE_ID_IN   = 8'h90;
    localparam logic [7:0] CODE_ESCAPE  = 8'hF0;
    localparam logic [7:0] CODE_CHIP    = 8'h10;
    localparam logic [7:0] CODE_MAIN    = 8'h30;
    localparam logic [7:0] CODE_LOCK    = 8'h40;

endpackage

// File: rtl/flash_cycle_classify.sv
// Module: classifies one write cycle against the two key addresses.
// Assumes: the top bit of the address is a don't-care and is not passed in.
module flash_cycle_classify #(
    parameter int          CMP_W     = 15,
    parameter logic [15:0] KEY_ADDR_A = 16'h5555,
    parameter logic [15:0] KEY_ADDR_B = 16'h2AAA
) (
    input  logic [CMP_W-1:0] addr_i,
    output logic             at_a_o,
    output logic             at_b_o
);

    // Compare the significant address bits with both key addresses.
    always_comb begin
        at_a_o = (addr_i == KEY_ADDR_A[CMP_W-1:0]);
        at_b_o = (addr_i == KEY_ADDR_B[CMP_W-1:0]);
    end

endmodule

// File: rtl/flash_seq_fsm.sv
// Module: unlock sequence state machine; issues one registered command per
// accepted write and captures the program target.
// Assumes: wr_stb_i is high for exactly one cycle per bus write.
module flash_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb_i,
    input  logic              oe_n_i,
    input  logic              busy_i,
    input  logic              at_a_i,
    input  logic              at_b_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output cmd_t              cmd_o,
    output logic [ADDR_W-1:0] prog_addr_o,
    output logic [DATA_W-1:0] prog_data_o
);

    seq_state_t state_q, state_d;
    cmd_t       cmd_q, cmd_d;
    logic [ADDR_W-1:0] prog_addr_q;
    logic [DATA_W-1:0] prog_data_q;
    logic       accept;
    logic [7:0] code;
    seq_state_t restart;

    // A write only counts when output enable is high and the engine is idle.
    always_comb begin
        accept  = wr_stb_i && oe_n_i && !busy_i;
        code    = wr_data_i[7:0];
        restart = (at_a_i && code == CODE_KEY_A) ? ST_KEY1 : ST_IDLE;
    end

    // Next state and command for the current write.
    always_comb begin
        state_d = state_q;
        cmd_d   = CMD_NONE;
        if (accept) begin
            if (state_q == ST_ARMED) begin
                cmd_d   = CMD_PROG;
                state_d = ST_IDLE;
            end else if (code == CODE_ESCAPE) begin
                cmd_d   = CMD_ID_OUT;
                state_d = ST_IDLE;
            end else begin
                unique case (state_q)
                    ST_IDLE: state_d = restart;
                    ST_KEY1: state_d = (at_b_i && code == CODE_KEY_B) ? ST_KEY2 : restart;
                    ST_KEY2: begin
                        state_d = restart;
                        if (at_a_i) begin
                            if (code == CODE_PROG)   state_d = ST_ARMED;
                            if (code == CODE_EXTEND) state_d = ST_EXT0;
                            if (code == CODE_ID_IN) begin
                                cmd_d   = CMD_ID_IN;
                                state_d = ST_IDLE;
                            end
                        end
                    end
                    ST_EXT0: state_d = (at_a_i && code == CODE_KEY_A) ? ST_EXT1 : restart;
                    ST_EXT1: state_d = (at_b_i && code == CODE_KEY_B) ? ST_EXT2 : restart;
                    ST_EXT2: begin
                        state_d = restart;
                        if (at_a_i) begin
                            if (code == CODE_CHIP) cmd_d = CMD_CHIP;
                            if (code == CODE_MAIN) cmd_d = CMD_MAIN;
                            if (code == CODE_LOCK) cmd_d = CMD_LOCK;
                            if (cmd_d != CMD_NONE) state_d = ST_IDLE;
                        end
                    end
                    default: state_d = ST_IDLE;
                endcase
            end
        end
    end

    // Register sequence state and the one-cycle command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= CMD_NONE;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_d;
        end
    end

    // Capture the program target on the write that completes a program.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_addr_q <= '0;
            prog_data_q <= '0;
        end else if (cmd_d == CMD_PROG) begin
            prog_addr_q <= wr_addr_i;
            prog_data_q <= wr_data_i;
        end
    end

    assign cmd_o       = cmd_q;
    assign prog_addr_o = prog_addr_q;
    assign prog_data_o = prog_data_q;

    // R9: a strobe during busy neither moves the sequence nor issues a command.
    assert_busy_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && busy_i) |=> ($stable(state_q) && cmd_q == CMD_NONE));

    // R8: a strobe with output enable low is ignored.
    assert_oe_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && !oe_n_i) |=> ($stable(state_q) && cmd_q == CMD_NONE));

    // R2: program only follows the armed state.
    assert_prog_from_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_PROG) |-> $past(state_q == ST_ARMED));

    // R4: erase and lockout only follow the full six-write unlock.
    assert_erase_from_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_CHIP || cmd_q == CMD_MAIN || cmd_q == CMD_LOCK)
        |-> $past(state_q == ST_EXT2));

    // R10: every command follows an accepted write strobe.
    assert_cmd_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q != CMD_NONE) |-> $past(wr_stb_i && oe_n_i && !busy_i));

endmodule

// File: rtl/flash_id_mode.sv
// Module: identification-mode flag and the identification read mux.
// Assumes: set and clear pulses come from the sequence decoder, never together.
module flash_id_mode #(
    parameter int          OFS_W    = 15,
    parameter int          DATA_W   = 16,
    parameter logic [15:0] MFR_CODE = 16'h001F,
    parameter logic [15:0] DEV_CODE = 16'h0087
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_set_i,
    input  logic              id_clr_i,
    input  logic              lock_status_i,
    input  logic [OFS_W-1:0]  rd_offset_i,
    output logic              id_mode_o,
    output logic [DATA_W-1:0] id_rd_data_o
);

    logic id_mode_q;

    // Hold the mode flag; reset always leaves identification mode.
    always_ff @(posedge clk) begin
        if (!rst_n)        id_mode_q <= 1'b0;
        else if (id_set_i) id_mode_q <= 1'b1;
        else if (id_clr_i) id_mode_q <= 1'b0;
    end

    // Select the identification word for the requested offset.
    always_comb begin
        id_rd_data_o = '0;
        if (id_mode_q) begin
            if (rd_offset_i == OFS_W'(0)) id_rd_data_o = MFR_CODE[DATA_W-1:0];
            if (rd_offset_i == OFS_W'(1)) id_rd_data_o = DEV_CODE[DATA_W-1:0];
            if (rd_offset_i == OFS_W'(2)) id_rd_data_o = {{(DATA_W-1){1'b0}}, lock_status_i};
        end
    end

    assign id_mode_o = id_mode_q;

    // R11: the flag rises only after an entry pulse.
    assert_id_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_mode_q) |-> $past(id_set_i));

    // R11: outside reset the flag falls only after an exit pulse.
    assert_id_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(id_mode_q) && $past(rst_n)) |-> $past(id_clr_i));

endmodule

// File: rtl/flash_cmd_decoder.sv
// Module: top of the flash unlock command decoder. Classifies each write,
// runs the sequence machine, fans the command out to one-hot pulses and
// keeps the identification mode.
// Assumes: synchronous single-cycle write strobes from the bus front end.
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 16,
    parameter logic [15:0] KEY_ADDR_A = 16'h5555,
    parameter logic [15:0] KEY_ADDR_B = 16'h2AAA,
    parameter logic [15:0] MFR_CODE   = 16'h001F,
    parameter logic [15:0] DEV_CODE   = 16'h0087
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              oe_n_i,
    input  logic              busy_i,
    input  logic              lock_status_i,
    input  logic [ADDR_W-2:0] rd_offset_i,
    output logic              cmd_prog_o,
    output logic [ADDR_W-1:0] prog_addr_o,
    output logic [DATA_W-1:0] prog_data_o,
    output logic              cmd_chip_erase_o,
    output logic              cmd_main_erase_o,
    output logic              cmd_lockout_o,
    output logic              cmd_id_enter_o,
    output logic              cmd_id_exit_o,
    output logic              id_mode_o,
    output logic [DATA_W-1:0] id_rd_data_o
);

    localparam int CMP_W = ADDR_W - 1;

    logic at_a, at_b;
    cmd_t cmd;
    logic [NUM_CMD-1:0] pulse_vec;

    flash_cycle_classify #(
        .CMP_W      (CMP_W),
        .KEY_ADDR_A (KEY_ADDR_A),
        .KEY_ADDR_B (KEY_ADDR_B)
    ) i_classify (
        .addr_i (wr_addr_i[CMP_W-1:0]),
        .at_a_o (at_a),
        .at_b_o (at_b)
    );

    flash_seq_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb_i    (wr_stb_i),
        .oe_n_i      (oe_n_i),
        .busy_i      (busy_i),
        .at_a_i      (at_a),
        .at_b_i      (at_b),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .cmd_o       (cmd),
        .prog_addr_o (prog_addr_o),
        .prog_data_o (prog_data_o)
    );

    // One pulse line per command code.
    for (genvar k = 0; k < NUM_CMD; k++) begin : g_pulse
        assign pulse_vec[k] = (cmd == cmd_t'(k + 1));
    end

    assign cmd_prog_o       = pulse_vec[0];
    assign cmd_chip_erase_o = pulse_vec[1];
    assign cmd_main_erase_o = pulse_vec[2];
    assign cmd_lockout_o    = pulse_vec[3];
    assign cmd_id_enter_o   = pulse_vec[4];
    assign cmd_id_exit_o    = pulse_vec[5];

    flash_id_mode #(
        .OFS_W    (CMP_W),
        .DATA_W   (DATA_W),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) i_id (
        .clk           (clk),
        .rst_n         (rst_n),
        .id_set_i      (pulse_vec[4]),
        .id_clr_i      (pulse_vec[5]),
        .lock_status_i (lock_status_i),
        .rd_offset_i   (rd_offset_i),
        .id_mode_o     (id_mode_o),
        .id_rd_data_o  (id_rd_data_o)
    );

    // R10: at most one command pulse per cycle.
    assert_one_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulse_vec));

endmodule

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        oe_n = 1'b1;
    logic        busy = 1'b0;
    logic        lock_status = 1'b0;
    logic [14:0] rd_offset = '0;
    logic        cmd_prog, cmd_chip, cmd_main, cmd_lock, cmd_in, cmd_out, id_mode;
    logic [15:0] prog_addr, prog_data, id_rd_data;

    always #2 clk = ~clk;

    flash_cmd_decoder i_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .oe_n_i(oe_n), .busy_i(busy),
        .lock_status_i(lock_status), .rd_offset_i(rd_offset),
        .cmd_prog_o(cmd_prog), .prog_addr_o(prog_addr), .prog_data_o(prog_data),
        .cmd_chip_erase_o(cmd_chip), .cmd_main_erase_o(cmd_main),
        .cmd_lockout_o(cmd_lock), .cmd_id_enter_o(cmd_in),
        .cmd_id_exit_o(cmd_out), .id_mode_o(id_mode), .id_rd_data_o(id_rd_data)
    );

    // Pulse kinds: {prog, chip, main, lock, id_in, id_out}
    localparam logic [5:0] K_PROG = 6'b100000, K_CHIP = 6'b010000, K_MAIN = 6'b001000,
                           K_LOCK = 6'b000100, K_IN   = 6'b000010, K_OUT  = 6'b000001;

    typedef struct {
        logic [5:0]  kind;
        logic [15:0] addr;
        logic [15:0] data;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;

    task automatic check16(string req, logic [15:0] act, logic [15:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic expect_cmd(logic [5:0] kind, logic [15:0] a, logic [15:0] d, string req);
        exp_t e;
        e.kind = kind; e.addr = a; e.data = d; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic wr(logic [15:0] a, logic [15:0] d, logic oe = 1'b1, logic bsy = 1'b0);
        @(negedge clk);
        wr_stb = 1'b1; wr_addr = a; wr_data = d; oe_n = oe; busy = bsy;
        @(negedge clk);
        wr_stb = 1'b0; oe_n = 1'b1; busy = 1'b0;
    endtask

    task automatic unlock();
        wr(16'h5555, 16'h00AA);
        wr(16'h2AAA, 16'h0055);
    endtask

    task automatic settle(string req);
        repeat (3) @(negedge clk);
        n_vec++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL %s pending commands actual=%0d expected=0", req, exp_q.size());
            exp_q.delete();
        end
    endtask

    // Monitor: every pulse observed is popped and compared with the queue head.
    always @(negedge clk) begin
        logic [5:0] pv;
        exp_t e;
        pv = {cmd_prog, cmd_chip, cmd_main, cmd_lock, cmd_in, cmd_out};
        if (rst_n && pv != 6'b0) begin
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R7/R10 unexpected pulse actual=%b expected=000000", pv);
            end else begin
                e = exp_q.pop_front();
                if (pv !== e.kind) begin
                    n_bad++;
                    $display("FAIL %s pulse actual=%b expected=%b", e.req, pv, e.kind);
                end else if (e.kind == K_PROG &&
                             (prog_addr !== e.addr || prog_data !== e.data)) begin
                    n_bad++;
                    $display("FAIL %s program target actual=%h/%h expected=%h/%h",
                             e.req, prog_addr, prog_data, e.addr, e.data);
                end
            end
        end
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check16("R1 pulses", {10'b0, cmd_prog, cmd_chip, cmd_main, cmd_lock, cmd_in, cmd_out}, 16'h0);
        check16("R1 id_mode", {15'b0, id_mode}, 16'h0);
        check16("R1 id_rd_data", id_rd_data, 16'h0000);
        @(negedge clk); rst_n = 1'b1;

        // R2: word program
        unlock(); wr(16'h5555, 16'h00A0);
        expect_cmd(K_PROG, 16'h8123, 16'hBEEF, "R2");
        wr(16'h8123, 16'hBEEF);
        settle("R2");
        check16("R2 prog_addr held", prog_addr, 16'h8123);

        // R2: F0 as program data is programmed, not an exit
        unlock(); wr(16'h5555, 16'h00A0);
        expect_cmd(K_PROG, 16'h3000, 16'h00F0, "R2 F0 data");
        wr(16'h3000, 16'h00F0);
        settle("R2 F0 data");

        // R3: upper data byte and address bit 15 are don't-care
        wr(16'hD555, 16'h12AA); wr(16'hAAAA, 16'hFF55); wr(16'hD555, 16'h77A0);
        expect_cmd(K_PROG, 16'h4000, 16'h0F0F, "R3");
        wr(16'h4000, 16'h0F0F);
        settle("R3");

        // R4: six-write selections
        unlock(); wr(16'h5555, 16'h0080); unlock();
        expect_cmd(K_CHIP, 0, 0, "R4 chip"); wr(16'h5555, 16'h0010);
        unlock(); wr(16'h5555, 16'h0080); unlock();
        expect_cmd(K_MAIN, 0, 0, "R4 main"); wr(16'h5555, 16'h0030);
        unlock(); wr(16'h5555, 16'h0080); unlock();
        expect_cmd(K_LOCK, 0, 0, "R4 lock"); wr(16'h5555, 16'h0040);
        settle("R4");

        // R6/R11: identification entry and reads
        unlock(); expect_cmd(K_IN, 0, 0, "R11 enter"); wr(16'h5555, 16'h0090);
        settle("R11 enter");
        check16("R11 id_mode set", {15'b0, id_mode}, 16'h1);
        rd_offset = 15'd0; #1 check16("R6 offset0", id_rd_data, 16'h001F);
        rd_offset = 15'd1; #1 check16("R6 offset1", id_rd_data, 16'h0087);
        rd_offset = 15'd2; #1 check16("R6 offset2 unlocked", id_rd_data, 16'h0000);
        lock_status = 1'b1; #1 check16("R6 offset2 locked", id_rd_data, 16'h0001);
        rd_offset = 15'd3; #1 check16("R6 offset3", id_rd_data, 16'h0000);

        // R5: three-write exit
        unlock(); expect_cmd(K_OUT, 0, 0, "R5 keyed exit"); wr(16'h5555, 16'h00F0);
        settle("R5 keyed exit");
        check16("R11 id_mode cleared", {15'b0, id_mode}, 16'h0);
        rd_offset = 15'd0; #1 check16("R6 not in id mode", id_rd_data, 16'h0000);

        // R5: single-write escape at any address
        unlock(); expect_cmd(K_IN, 0, 0, "R5 re-enter"); wr(16'h5555, 16'h0090);
        expect_cmd(K_OUT, 0, 0, "R5 escape"); wr(16'h1234, 16'h00F0);
        settle("R5 escape");
        check16("R5 id_mode after escape", {15'b0, id_mode}, 16'h0);

        // R5: escape in the middle of a six-write sequence
        unlock(); wr(16'h5555, 16'h0080);
        expect_cmd(K_OUT, 0, 0, "R5 mid escape"); wr(16'h0000, 16'hABF0);
        settle("R5 mid escape");

        // R7: broken sequence re-checked as first unlock write
        wr(16'h5555, 16'h00AA); unlock(); wr(16'h5555, 16'h00A0);
        expect_cmd(K_PROG, 16'h0100, 16'h5678, "R7 recheck");
        wr(16'h0100, 16'h5678);
        unlock(); wr(16'h5555, 16'h0077); wr(16'h2222, 16'h1111);
        settle("R7");

        // R8: output enable low ignores the write
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055, 1'b0); wr(16'h5555, 16'h00A0);
        wr(16'h0200, 16'h2222);
        settle("R8");
        check16("R8 prog_addr unchanged", prog_addr, 16'h0100);
        unlock(); wr(16'h5555, 16'h0090, 1'b0);
        settle("R8 id");
        check16("R8 id_mode untouched", {15'b0, id_mode}, 16'h0);

        // R9: busy ignores the write
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055, 1'b1, 1'b1); wr(16'h5555, 16'h00A0);
        wr(16'h0300, 16'h3333);
        settle("R9");
        check16("R9 prog_data unchanged", prog_data, 16'h5678);
        unlock(); wr(16'h5555, 16'h00A0); wr(16'h0300, 16'h9999, 1'b1, 1'b1);
        expect_cmd(K_PROG, 16'h0400, 16'h4444, "R9 armed kept");
        wr(16'h0400, 16'h4444);
        settle("R9 armed kept");

        // R11: reset leaves identification mode
        unlock(); expect_cmd(K_IN, 0, 0, "R11 enter2"); wr(16'h5555, 16'h0090);
        settle("R11 enter2");
        check16("R11 id_mode before reset", {15'b0, id_mode}, 16'h1);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check16("R11 id_mode after reset", {15'b0, id_mode}, 16'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule